// File: doc/BRIEF.md
# Halfword-select signed multiply-accumulate unit

This block is a signed DSP multiply-accumulate datapath that treats each 32-bit operand as two 16-bit halves. One opcode picks the operation. It can multiply one chosen half of `a_i` by one chosen half of `b_i`. It can multiply the whole of `a_i` by a chosen half of `b_i` and keep the upper 32 bits of the 48-bit product. It can form bottom and top products in parallel and add them, or subtract the top product from the bottom one. Each of these forms can also add into a 32-bit accumulator or into a 64-bit accumulator.

A 32-bit result wraps on overflow and is never saturated. When the exact value does not fit in 32 signed bits, the unit raises `q_o` for one cycle so that the surrounding core can set its sticky saturation flag. Results written to the 64-bit accumulator wrap modulo 2^64 and never raise `q_o`. A new operation may be issued on every cycle. Its result appears on the registered outputs at the next clock edge. Instruction decode and register writeback belong to the surrounding pipeline.

Top module: `smac_unit`

## Requirements
- R1: Opcode 0 returns the signed 32-bit product of the `a_i` half chosen by `sel_a_i` and the `b_i` half chosen by `sel_b_i`. A select value of 0 picks bits 15:0 and 1 picks bits 31:16. This opcode never raises `q_o`.
- R2: Opcode 1 adds the R1 product to `acc_lo_i` and wraps the sum to 32 bits. `q_o` is raised when the exact sum lies outside the signed 32-bit range.
- R3: Opcode 2 sign-extends the R1 product and adds it to `{acc_hi_i, acc_lo_i}` modulo 2^64. This opcode never raises `q_o`.
- R4: Opcode 3 multiplies the signed `a_i` by the signed `b_i` half chosen by `sel_b_i` and returns bits 47:16 of the 48-bit product. This opcode never raises `q_o`.
- R5: Opcode 4 adds the R4 value to `acc_lo_i` and wraps the sum to 32 bits. `q_o` is raised when the exact sum overflows.
- R6: Opcode 5 returns the bottom product plus the top product. The bottom product is `a_i[15:0]` times `b_i[15:0]` and the top product is `a_i[31:16]` times `b_i[31:16]`. If `swap_i` is 1, the two halves of `b_i` are exchanged before multiplying. `q_o` is raised when the exact sum overflows 32 bits.
- R7: Opcode 6 returns the bottom product minus the top product, with the same exchange option as R6. This opcode never raises `q_o`.
- R8: Opcodes 7 (sum) and 8 (difference) add the dual result to `acc_lo_i`. `q_o` is raised only when the exact three-term total lies outside the signed 32-bit range. The intermediate dual result may overflow without raising `q_o`.
- R9: Opcodes 9 (sum) and 10 (difference) add the sign-extended dual result to `{acc_hi_i, acc_lo_i}` modulo 2^64. These opcodes never raise `q_o`.
- R10: `valid_o`, `res_o` and `q_o` reflect the operation issued with `valid_i` at the previous rising edge. When `valid_i` was low, `valid_o` and `q_o` are 0 and `res_o` holds its previous value.
- R11: For every 32-bit form, `res_o[63:32]` is the sign extension of `res_o[31:0]`.
- R12: While `rst_ni` is low, `valid_o`, `q_o` and `res_o` are all 0.
- R13: Opcodes 11 to 15 give a result of 0 and never raise `q_o`.
- R14: `sel_a_i` and `sel_b_i` have no effect on opcodes 5 to 10, and `swap_i` has no effect on opcodes 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Issue an operation this cycle |
| op_i | input | 4 | Opcode (see R1 to R13) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| acc_lo_i | input | 32 | Accumulator low word, also the 32-bit accumulator |
| acc_hi_i | input | 32 | Accumulator high word |
| sel_a_i | input | 1 | Half select for `a_i` (0 bottom, 1 top) |
| sel_b_i | input | 1 | Half select for `b_i` (0 bottom, 1 top) |
| swap_i | input | 1 | Exchange the halves of `b_i` in the dual forms |
| valid_o | output | 1 | Result valid |
| res_o | output | 64 | Result; 32-bit forms are sign-extended |
| q_o | output | 1 | One-cycle overflow pulse for the sticky saturation flag |

## Verification
The datapath is stateless apart from its output register. A wrong half select, a wrong exchange or a wrong product sign therefore shows up as a wrong `res_o` on the very next cycle. An overflow test done at the wrong width shows up in the same cycle as a missing or spurious `q_o`. This is most visible when a dual sum overflows but the accumulator brings the total back into range. A stuck output register shows up as `res_o` moving, or `q_o` pulsing, on a cycle in which nothing was issued. The bench sweeps every opcode against every select and exchange combination over corner and scrambled operands, and compares each result with an arithmetic model.

// File: rtl/smac_pkg.sv
package smac_pkg;
  typedef enum logic [3:0] {
    OP_MUL_HH        = 4'd0,
    OP_MAC_HH        = 4'd1,
    OP_MACL_HH       = 4'd2,
    OP_MUL_HW        = 4'd3,
    OP_MAC_HW        = 4'd4,
    OP_DUAL_ADD      = 4'd5,
    OP_DUAL_SUB      = 4'd6,
    OP_DUAL_ADD_ACC  = 4'd7,
    OP_DUAL_SUB_ACC  = 4'd8,
    OP_DUAL_ADD_ACCL = 4'd9,
    OP_DUAL_SUB_ACCL = 4'd10
  } smac_op_e;

  function automatic logic is_wide(input logic [3:0] op);
    return op == OP_MACL_HH || op == OP_DUAL_ADD_ACCL || op == OP_DUAL_SUB_ACCL;
  endfunction

  function automatic logic is_dual(input logic [3:0] op);
    return op >= OP_DUAL_ADD && op <= OP_DUAL_SUB_ACCL;
  endfunction
endpackage

// File: rtl/smac_opsel.sv
module smac_opsel #(
  parameter int unsigned HW = 16,
  localparam int unsigned W = 2 * HW
) (
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  input  logic                 sel_a_i,
  input  logic                 sel_b_i,
  input  logic                 swap_i,
  input  logic                 dual_i,
  output logic [1:0][HW-1:0]   ha_o,
  output logic [1:0][HW-1:0]   hb_o
);
  logic [W-1:0] b_x;

  assign b_x = swap_i ? {b_i[HW-1:0], b_i[W-1:HW]} : b_i;

  // lane 0: selected halves (single) or bottom pair (dual); lane 1: top pair
  assign ha_o[0] = dual_i ? a_i[HW-1:0] : (sel_a_i ? a_i[W-1:HW] : a_i[HW-1:0]);
  assign hb_o[0] = dual_i ? b_x[HW-1:0] : (sel_b_i ? b_i[W-1:HW] : b_i[HW-1:0]);
  assign ha_o[1] = a_i[W-1:HW];
  assign hb_o[1] = b_x[W-1:HW];
endmodule

// File: rtl/smac_mul.sv
module smac_mul #(
  parameter int unsigned HW = 16,
  localparam int unsigned W  = 2 * HW,
  localparam int unsigned XW = 3 * HW
) (
  input  logic [1:0][HW-1:0] ha_i,
  input  logic [1:0][HW-1:0] hb_i,
  input  logic [W-1:0]       a_i,
  output logic [1:0][W-1:0]  hp_o,
  output logic [W-1:0]       wp_o
);
  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic [W-1:0] xa, xb;
    assign xa = {{HW{ha_i[k][HW-1]}}, ha_i[k]};
    assign xb = {{HW{hb_i[k][HW-1]}}, hb_i[k]};
    assign hp_o[k] = W'($signed(xa) * $signed(xb));
  end

  // word x half on lane 0's b half; keep bits XW-1:HW
  logic [XW-1:0] wa, wb, wfull;
  assign wa    = {{HW{a_i[W-1]}}, a_i};
  assign wb    = {{W{hb_i[0][HW-1]}}, hb_i[0]};
  assign wfull = XW'($signed(wa) * $signed(wb));
  assign wp_o  = wfull[XW-1:HW];
endmodule

// File: rtl/smac_sum.sv
module smac_sum
  import smac_pkg::*;
#(
  parameter int unsigned HW = 16,
  localparam int unsigned W  = 2 * HW,
  localparam int unsigned LW = 4 * HW,
  localparam int unsigned EW = W + 3
) (
  input  logic [3:0]         op_i,
  input  logic [1:0][W-1:0]  hp_i,
  input  logic [W-1:0]       wp_i,
  input  logic [W-1:0]       acc_lo_i,
  input  logic [W-1:0]       acc_hi_i,
  output logic [LW-1:0]      res_o,
  output logic               q_o
);
  logic [EW-1:0] e0, e1, ew, ea, s32;
  logic [LW-1:0] l0, l1, acc64, s64;
  logic          q32;

  assign e0    = {{3{hp_i[0][W-1]}}, hp_i[0]};
  assign e1    = {{3{hp_i[1][W-1]}}, hp_i[1]};
  assign ew    = {{3{wp_i[W-1]}}, wp_i};
  assign ea    = {{3{acc_lo_i[W-1]}}, acc_lo_i};
  assign l0    = {{W{hp_i[0][W-1]}}, hp_i[0]};
  assign l1    = {{W{hp_i[1][W-1]}}, hp_i[1]};
  assign acc64 = {acc_hi_i, acc_lo_i};

  // full-precision 32-bit path
  always_comb begin
    unique case (op_i)
      OP_MUL_HH:       s32 = e0;
      OP_MAC_HH:       s32 = e0 + ea;
      OP_MUL_HW:       s32 = ew;
      OP_MAC_HW:       s32 = ew + ea;
      OP_DUAL_ADD:     s32 = e0 + e1;
      OP_DUAL_SUB:     s32 = e0 - e1;
      OP_DUAL_ADD_ACC: s32 = e0 + e1 + ea;
      OP_DUAL_SUB_ACC: s32 = e0 - e1 + ea;
      default:         s32 = '0;
    endcase
  end

  // wrapping 64-bit path
  always_comb begin
    unique case (op_i)
      OP_MACL_HH:       s64 = l0 + acc64;
      OP_DUAL_ADD_ACCL: s64 = l0 + l1 + acc64;
      OP_DUAL_SUB_ACCL: s64 = l0 - l1 + acc64;
      default:          s64 = '0;
    endcase
  end

  // fits in W signed bits iff the top four bits agree
  assign q32   = !((&s32[EW-1:W-1]) || !(|s32[EW-1:W-1]));
  assign q_o   = is_wide(op_i) ? 1'b0 : q32;
  assign res_o = is_wide(op_i) ? s64 : {{W{s32[W-1]}}, s32[W-1:0]};
endmodule

// File: rtl/smac_unit.sv
module smac_unit
  import smac_pkg::*;
#(
  parameter int unsigned HW = 16,
  localparam int unsigned W  = 2 * HW,
  localparam int unsigned LW = 4 * HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  acc_lo_i,
  input  logic [W-1:0]  acc_hi_i,
  input  logic          sel_a_i,
  input  logic          sel_b_i,
  input  logic          swap_i,
  output logic          valid_o,
  output logic [LW-1:0] res_o,
  output logic          q_o
);
  logic [1:0][HW-1:0] ha, hb;
  logic [1:0][W-1:0]  hp;
  logic [W-1:0]       wp;
  logic [LW-1:0]      res_d;
  logic               q_d;

  smac_opsel #(.HW(HW)) u_opsel (
    .a_i(a_i), .b_i(b_i), .sel_a_i(sel_a_i), .sel_b_i(sel_b_i),
    .swap_i(swap_i), .dual_i(is_dual(op_i)), .ha_o(ha), .hb_o(hb)
  );

  smac_mul #(.HW(HW)) u_mul (
    .ha_i(ha), .hb_i(hb), .a_i(a_i), .hp_o(hp), .wp_o(wp)
  );

  smac_sum #(.HW(HW)) u_sum (
    .op_i(op_i), .hp_i(hp), .wp_i(wp), .acc_lo_i(acc_lo_i),
    .acc_hi_i(acc_hi_i), .res_o(res_d), .q_o(q_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      q_o     <= valid_i & q_d;
      if (valid_i) res_o <= res_d;
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R10
  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !q_o); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o)); // R10
  AST_WIDE_NO_Q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_wide(op_i)) |=> !q_o); // R3
  AST_SEXT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_wide(op_i)) |=> res_o[LW-1:W] == {W{res_o[W-1]}}); // R11
  AST_DIFF_NO_Q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_DUAL_SUB) |=> !q_o); // R7
  AST_MUL_NO_Q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_MUL_HH || op_i == OP_MUL_HW)) |=> !q_o); // R4
  AST_UNDEF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 4'd10) |=> (res_o == '0 && !q_o)); // R13
endmodule

// File: tb/tb_smac_unit.sv
module tb_smac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0, acc_lo_i = '0, acc_hi_i = '0;
  logic        sel_a_i = 1'b0, sel_b_i = 1'b0, swap_i = 1'b0;
  logic        valid_o, q_o;
  logic [63:0] res_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  smac_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .acc_lo_i(acc_lo_i), .acc_hi_i(acc_hi_i),
    .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .swap_i(swap_i),
    .valid_o(valid_o), .res_o(res_o), .q_o(q_o)
  );

  function automatic longint sx16(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint sx32(input logic [31:0] v);
    return longint'($signed(v));
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7, 4'd8: return "R8";
      4'd9, 4'd10: return "R9";
      default: return "R13";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [31:0] a, b, al, ah,
                       input logic sa, sb, sw, output logic [63:0] r, output logic q);
    logic [31:0] bx;
    longint x0, xw, db, dt, a32, a64, s;
    bit wide;
    bx  = sw ? {b[15:0], b[31:16]} : b;
    x0  = sx16(sa ? a[31:16] : a[15:0]) * sx16(sb ? b[31:16] : b[15:0]);
    xw  = (sx32(a) * sx16(sb ? b[31:16] : b[15:0])) >>> 16;
    db  = sx16(a[15:0]) * sx16(bx[15:0]);
    dt  = sx16(a[31:16]) * sx16(bx[31:16]);
    a32 = sx32(al);
    a64 = longint'({ah, al});
    wide = 1'b0;
    case (op)
      4'd0:  s = x0;
      4'd1:  s = x0 + a32;
      4'd2:  begin s = x0 + a64; wide = 1'b1; end
      4'd3:  s = xw;
      4'd4:  s = xw + a32;
      4'd5:  s = db + dt;
      4'd6:  s = db - dt;
      4'd7:  s = db + dt + a32;
      4'd8:  s = db - dt + a32;
      4'd9:  begin s = db + dt + a64; wide = 1'b1; end
      4'd10: begin s = db - dt + a64; wide = 1'b1; end
      default: s = 0;
    endcase
    if (wide) begin
      r = s; q = 1'b0;
    end else begin
      q = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      r = sx32(s[31:0]);
    end
  endtask

  task automatic check(input string req, input logic [63:0] act_r, exp_r,
                       input logic act_q, exp_q, act_v, exp_v);
    n_chk++;
    if (act_r !== exp_r || act_q !== exp_q || act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: res=%h q=%b v=%b expected res=%h q=%b v=%b",
               req, act_r, act_q, act_v, exp_r, exp_q, exp_v);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, b, al, ah,
                       input logic sa, sb, sw);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; acc_lo_i = al; acc_hi_i = ah;
    sel_a_i = sa; sel_b_i = sb; swap_i = sw;
    @(negedge clk);
  endtask

  task automatic run(input logic [3:0] op, input logic [31:0] a, b, al, ah,
                     input logic sa, sb, sw);
    logic [63:0] er;
    logic eq;
    model(op, a, b, al, ah, sa, sb, sw, er, eq);
    issue(op, a, b, al, ah, sa, sb, sw);
    check(req_of(op), res_o, er, q_o, eq, valid_o, 1'b1);
  endtask

  task automatic run_exp(input string req, input logic [3:0] op, input logic [31:0] a, b, al, ah,
                         input logic sa, sb, sw, input logic [63:0] er, input logic eq);
    issue(op, a, b, al, ah, sa, sb, sw);
    check(req, res_o, er, q_o, eq, valid_o, 1'b1);
  endtask

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h7FFF_7FFF;
      2: return 32'h8000_8000;
      3: return 32'h8000_7FFF;
      4: return 32'hFFFF_FFFF;
      5: return 32'h0001_0001;
      6: return 32'h7FFF_8000;
      7: return 32'h1234_5678;
      default: return (i * 32'h9E37_79B9) ^ (i << 7);
    endcase
  endfunction

  function automatic logic [31:0] apat(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'hFFFF_FFFF;
      default: return 32'hC0DE_1357 ^ (i * 32'h0101_0101);
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", res_o, 64'h0, q_o, 1'b0, valid_o, 1'b0);
    rst_n = 1'b1;

    // directed corners
    run_exp("R1", 4'd0, 32'h0003_FFFE, 32'h0005_0007, 0, 0, 1'b1, 1'b0, 1'b0, 64'h15, 1'b0);
    run_exp("R1", 4'd0, 32'h0003_FFFE, 32'h0005_0007, 0, 0, 1'b0, 1'b1, 1'b0,
            64'hFFFF_FFFF_FFFF_FFF6, 1'b0);
    run_exp("R2", 4'd1, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 1'b0, 1'b0, 1'b0,
            64'hFFFF_FFFF_BFFF_0000, 1'b1);
    run_exp("R3", 4'd2, 32'h0001_0001, 32'h0001_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
            1'b0, 1'b0, 1'b0, 64'h0, 1'b0);
    run_exp("R4", 4'd3, 32'h0001_0000, 32'h0000_0003, 0, 0, 1'b0, 1'b0, 1'b0, 64'h3, 1'b0);
    run_exp("R5", 4'd4, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 1'b0, 1'b0, 1'b0,
            64'hFFFF_FFFF_BFFF_7FFE, 1'b1);
    run_exp("R6", 4'd5, 32'h8000_8000, 32'h8000_8000, 0, 0, 1'b0, 1'b0, 1'b0,
            64'hFFFF_FFFF_8000_0000, 1'b1);
    run_exp("R6", 4'd5, 32'h0002_0003, 32'h0005_0007, 0, 0, 1'b0, 1'b0, 1'b1, 64'h1D, 1'b0);
    run_exp("R7", 4'd6, 32'h0002_0003, 32'h0005_0007, 0, 0, 1'b0, 1'b0, 1'b0, 64'hB, 1'b0);
    run_exp("R8", 4'd7, 32'h8000_8000, 32'h8000_8000, 32'h8000_0000, 0, 1'b0, 1'b0, 1'b0,
            64'h0, 1'b0);
    run_exp("R8", 4'd7, 32'h8000_8000, 32'h8000_8000, 32'h0000_0001, 0, 1'b0, 1'b0, 1'b0,
            64'hFFFF_FFFF_8000_0001, 1'b1);
    run_exp("R9", 4'd10, 32'h0001_0000, 32'h0001_0000, 0, 0, 1'b0, 1'b0, 1'b0,
            64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    run_exp("R13", 4'd12, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_FFFF, 1, 1'b1, 1'b1, 1'b1,
            64'h0, 1'b0);

    // R14: controls outside their forms have no effect
    for (int k = 0; k < 8; k++) begin
      run_exp("R14", 4'd6, 32'h0002_0003, 32'h0005_0007, 0, 0, k[0], k[1], 1'b0, 64'hB, 1'b0);
      run_exp("R14", 4'd0, 32'h0003_FFFE, 32'h0005_0007, 0, 0, 1'b1, 1'b0, k[2], 64'h15, 1'b0);
    end

    // R10: an idle cycle changes nothing and gives no valid or Q
    run_exp("R10", 4'd5, 32'h8000_8000, 32'h8000_8000, 0, 0, 1'b0, 1'b0, 1'b0,
            64'hFFFF_FFFF_8000_0000, 1'b1);
    valid_i = 1'b0; op_i = 4'd0; a_i = 32'h1111_2222; b_i = 32'h3333_4444;
    @(negedge clk);
    check("R10", res_o, 64'hFFFF_FFFF_8000_0000, q_o, 1'b0, valid_o, 1'b0);

    // sweep: every opcode x select/exchange combination x operand sets
    for (int op = 0; op < 16; op++)
      for (int c = 0; c < 8; c++)
        for (int i = 0; i < 10; i++)
          run(4'(op), pat(i), pat((i * 3 + c) % 12), apat((i + c + op) % 6),
              apat((i * 5 + op) % 6), c[0], c[1], c[2]);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule